// File: doc/BRIEF.md
# Indirect Index/Data Register Window

This block lets a host reach a large bank of internal 32-bit registers through only two I/O locations. The host first writes a register offset into an index location at window offset 0. It then reads or writes the data location at window offset 4. Each data access is passed to an internal register bus as a single dword transfer, aimed at the dword-aligned offset held in the index.

The host side is a simple slave port. A request is held with `h_sel` until the block answers with a one-cycle `h_ready` pulse. The register-bus side is a master port that keeps `m_req` raised until the target returns `m_ack`. Only one forwarded transfer is in flight at any time. Accesses narrower than 32 bits follow their own rules:
- a narrow index write is answered but does not change the index;
- a narrow data read returns only the enabled byte lanes;
- a narrow data write is forwarded with its byte enables and raises a warning flag.

Top module: `idx_data_window`

## Requirements
- R1: After reset, the index reads as 00000000h, and both `h_ready` and `m_req` are low.
- R2: A write to window offset 0 with all four byte enables set (`h_be`=4'b1111) loads the index from `h_wdata`. Bits 1:0 are always stored and read back as zero.
- R3: A write to offset 0 with any byte enable clear is completed with `h_ready`, but the index keeps its previous value.
- R4: A read of offset 0 returns the index on the enabled byte lanes. Disabled lanes read zero.
- R5: A full write to offset 4 issues one master write with `m_write`=1, `m_addr` = index with bits 1:0 zero, `m_be`=4'b1111 and `m_wdata` = host data.
- R6: A read of offset 4 issues one master read at the indexed address. `h_rdata` returns `m_rdata` masked to the host's enabled byte lanes, whether the read is full or partial.
- R7: A partial write to offset 4 is forwarded with its byte enables. `h_unsup` is high in the same cycle as its `h_ready`, and low for every other access.
- R8: For a data-port access, `h_ready` stays low until the cycle after `m_ack`. `m_req` stays high until `m_ack`, and no second master request starts while one is pending.
- R9: An access to any window offset other than 0 or 4 completes with `h_ready` and returns zero. It issues no master request and leaves the index unchanged.
- R10: `h_ready` is never high for two consecutive cycles. Each host request held on `h_sel` is answered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host request, held until `h_ready` |
| h_write | input | 1 | Host write (1) or read (0) |
| h_addr | input | WIN_AW | Byte offset within the window |
| h_be | input | DW/8 | Host byte enables |
| h_wdata | input | DW | Host write data |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | DW | Read data, valid with `h_ready` |
| h_unsup | output | 1 | Partial data-port write flag, with `h_ready` |
| m_req | output | 1 | Register-bus request, held until `m_ack` |
| m_write | output | 1 | Register-bus write (1) or read (0) |
| m_addr | output | DW | Dword-aligned register byte address |
| m_be | output | DW/8 | Register-bus byte enables |
| m_wdata | output | DW | Register-bus write data |
| m_ack | input | 1 | Register-bus completion, with `m_rdata` |
| m_rdata | input | DW | Register-bus read data |

## Verification
The two events that can meet in one cycle are the completion of a forwarded transfer and the arrival of the host's next request. The host presents a new request at the same edge at which it sees `h_ready`. The target model can acknowledge with no added latency, so the acknowledge, the ready pulse and a fresh data-port request land on adjacent edges.

The bench judges this case in three ways:
- the returned data must match its own model of the register space;
- exactly one master request must be counted per data-port access;
- `h_ready` must never be seen high on two successive cycles.

// File: rtl/idx_data_window.sv
module idx_data_window #(
  parameter int DW     = 32,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_write,
  input  logic [WIN_AW-1:0] h_addr,
  input  logic [DW/8-1:0]   h_be,
  input  logic [DW-1:0]     h_wdata,
  output logic              h_ready,
  output logic [DW-1:0]     h_rdata,
  output logic              h_unsup,
  output logic              m_req,
  output logic              m_write,
  output logic [DW-1:0]     m_addr,
  output logic [DW/8-1:0]   m_be,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata
);
  localparam int BW = DW / 8;
  localparam logic [WIN_AW-1:0] OFS_IDX = '0;
  localparam logic [WIN_AW-1:0] OFS_DAT = WIN_AW'(4);

  logic [DW-1:0] idx_q;
  logic          busy_q;

  wire accept  = h_sel && !h_ready && !busy_q;
  wire full_be = &h_be;
  wire at_idx  = (h_addr == OFS_IDX);
  wire at_dat  = (h_addr == OFS_DAT);

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < BW; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      h_ready <= 1'b0;
      h_rdata <= '0;
      h_unsup <= 1'b0;
      m_req   <= 1'b0;
      m_write <= 1'b0;
      m_addr  <= '0;
      m_be    <= '0;
      m_wdata <= '0;
    end else begin
      h_ready <= 1'b0;
      h_unsup <= 1'b0;
      if (accept) begin
        if (at_dat) begin
          busy_q  <= 1'b1;
          m_req   <= 1'b1;
          m_write <= h_write;
          m_addr  <= {idx_q[DW-1:2], 2'b00};
          m_be    <= h_be;
          m_wdata <= h_wdata;
        end else begin
          h_ready <= 1'b1;
          h_rdata <= (at_idx && !h_write) ? lanes(idx_q, h_be) : '0;
          if (at_idx && h_write && full_be) idx_q <= {h_wdata[DW-1:2], 2'b00};
        end
      end
      if (busy_q && m_ack) begin
        busy_q  <= 1'b0;
        m_req   <= 1'b0;
        h_ready <= 1'b1;
        h_rdata <= m_write ? '0 : lanes(m_rdata, m_be);
        h_unsup <= m_write && !(&m_be);
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $past(!rst_n) |-> (!h_ready && !m_req && idx_q == '0));

  a_r2_index_aligned: assert property (@(posedge clk) disable iff (!rst_n) idx_q[1:0] == 2'b00);

  a_r3_partial_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_idx && h_write && !full_be) |=> $stable(idx_q));

  a_r7_unsup_with_ready: assert property (@(posedge clk) disable iff (!rst_n) h_unsup |-> h_ready);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n) (m_req && !m_ack) |=> m_req);

  a_r8_ack_completes: assert property (@(posedge clk) disable iff (!rst_n) (m_req && m_ack) |=> (h_ready && !m_req));

  a_r9_no_master_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !at_dat) |=> !m_req);

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n) h_ready |=> !h_ready);
endmodule

// File: tb/idx_data_window_test.sv
module idx_data_window_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        h_sel = 0, h_write = 0;
  logic [3:0]  h_addr = '0;
  logic [3:0]  h_be = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_unsup, m_req, m_write;
  logic [31:0] h_rdata, m_addr, m_wdata;
  logic [3:0]  m_be;
  logic        m_ack = 0;
  logic [31:0] m_rdata = '0;

  always #5 clk = ~clk;

  idx_data_window uut (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_write(h_write), .h_addr(h_addr),
    .h_be(h_be), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata), .h_unsup(h_unsup),
    .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata));

  int n_chk = 0, n_fail = 0;
  int lat = 0, lat_cnt = 0, req_count = 0;
  logic [31:0] space [256];
  logic [31:0] ref_idx = '0;
  logic [3:0]  last_be = '0;
  logic        prev_ready = 0, prev_req = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  // target register space
  always @(posedge clk) begin
    m_ack <= 1'b0;
    if (m_req && !m_ack) begin
      if (lat_cnt >= lat) begin
        lat_cnt <= 0;
        m_ack   <= 1'b1;
        last_be <= m_be;
        if (m_write) begin
          if (m_addr[31:2] < 256)
            for (int i = 0; i < 4; i++)
              if (m_be[i]) space[m_addr[9:2]][i*8 +: 8] <= m_wdata[i*8 +: 8];
        end else begin
          m_rdata <= (m_addr[31:2] < 256) ? space[m_addr[9:2]] : 32'h0;
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // per-cycle reference comparison
  always @(negedge clk) if (rst_n) begin
    if (h_ready && prev_ready) chk(0, "R10 ready pulse", 1, 0);
    if (m_req) chk(m_addr == {ref_idx[31:2], 2'b00}, "R5 master address", m_addr, {ref_idx[31:2], 2'b00});
    if (m_req && !prev_req) req_count++;
    prev_ready = h_ready;
    prev_req   = m_req;
  end

  task automatic host(input logic [3:0] a, input bit wr, input logic [3:0] be, input logic [31:0] wd,
                      output logic [31:0] rd, output logic un, output int cyc);
    h_sel = 1; h_write = wr; h_addr = a; h_be = be; h_wdata = wd;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (h_ready) begin
        rd = h_rdata; un = h_unsup;
        h_sel = 0;
        break;
      end
    end
    if (wr && a == 0 && be == 4'hF) ref_idx = {wd[31:2], 2'b00};
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic un; int cyc, rc;
    for (int i = 0; i < 256; i++) space[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    chk(!h_ready && !m_req, "R1 outputs idle", {h_ready, m_req}, 0);
    rst_n = 1;
    @(negedge clk);
    host(4'h0, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 0, "R1 index reset", rd, 0);

    host(4'h0, 1, 4'hF, 32'h0000_0013, rd, un, cyc);
    host(4'h0, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 32'h10, "R2 index load low bits zero", rd, 32'h10);

    host(4'h0, 1, 4'h3, 32'hFFFF_FFFF, rd, un, cyc);
    host(4'h0, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 32'h10, "R3 partial index write ignored", rd, 32'h10);

    host(4'h0, 1, 4'hF, 32'h0000_0A64, rd, un, cyc);
    host(4'h0, 0, 4'h2, 0, rd, un, cyc);
    chk(rd == 32'h0000_0A00, "R4 index partial read lanes", rd, 32'h0000_0A00);

    host(4'h0, 1, 4'hF, 32'h0000_0010, rd, un, cyc);
    rc = req_count;
    host(4'h4, 1, 4'hF, 32'hCAFE_F00D, rd, un, cyc);
    chk(space[4] == 32'hCAFE_F00D, "R5 data write forwarded", space[4], 32'hCAFE_F00D);
    chk(last_be == 4'hF && !un, "R5 full enables no flag", {un, last_be}, 4'hF);
    chk(req_count == rc + 1, "R8 one request", req_count, rc + 1);

    host(4'h4, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 32'hCAFE_F00D, "R6 data read", rd, 32'hCAFE_F00D);
    host(4'h4, 0, 4'hC, 0, rd, un, cyc);
    chk(rd == 32'hCAFE_0000, "R6 partial data read", rd, 32'hCAFE_0000);

    host(4'h4, 1, 4'h2, 32'h0000_5500, rd, un, cyc);
    chk(un == 1, "R7 unsupported flag", un, 1);
    chk(space[4] == 32'hCAFE_550D, "R7 enables forwarded", space[4], 32'hCAFE_550D);
    host(4'h4, 0, 4'hF, 0, rd, un, cyc);
    chk(un == 0, "R7 flag clear on read", un, 0);

    lat = 4;
    host(4'h4, 0, 4'hF, 0, rd, un, cyc);
    chk(cyc >= 6, "R8 ready waits for ack", cyc, 6);
    chk(rd == 32'hCAFE_550D, "R8 slow read data", rd, 32'hCAFE_550D);
    lat = 0;

    rc = req_count;
    host(4'h8, 1, 4'hF, 32'hFFFF_FFFF, rd, un, cyc);
    host(4'h8, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 0, "R9 other offset reads zero", rd, 0);
    host(4'h0, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 32'h10, "R9 index unaffected", rd, 32'h10);
    chk(req_count == rc, "R9 no master request", req_count, rc);

    host(4'h0, 1, 4'hF, 32'h0000_0020, rd, un, cyc);
    rc = req_count;
    host(4'h4, 1, 4'hF, 32'h1234_5678, rd, un, cyc);
    host(4'h4, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 32'h1234_5678, "R10 back-to-back data", rd, 32'h1234_5678);
    chk(req_count == rc + 2, "R10 one request per access", req_count, rc + 2);

    host(4'h0, 1, 4'hF, 32'h0000_0400, rd, un, cyc);
    host(4'h4, 1, 4'hF, 32'hDEAD_BEEF, rd, un, cyc);
    host(4'h4, 0, 4'hF, 0, rd, un, cyc);
    chk(rd == 0, "R6 out-of-range target reads zero", rd, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule